// File: doc/BRIEF.md
# Calendar Real-Time Clock with Alarms and Stopwatch

This block keeps wall-clock time from a slow reference clock. A prescaler counts reference cycles and emits one tick per second. The tick steps a cascade of counters for seconds, minutes, hours and a free-running day count. Two comparators watch the time as it advances. One fires at a given hour, minute and second on every day. The other also needs a given day count. A minute-granular countdown stopwatch signals when it passes below zero.

Six event sources each set a sticky status bit, but only while their enable bit is set. The sources are the second tick, minute rollover, day rollover, the two alarms and the stopwatch. Software clears a status bit by writing 1 to it. One interrupt line is the OR of the status bits that are also enabled. A small register port serves all programming and reading. Writes take effect at the clock edge. Reads are combinational.

Register addresses are 0 time, 1 daily alarm, 2 dated alarm, 3 stopwatch count, 4 enables and 5 status. Time and alarm words use bits 5:0 for seconds, 13:8 for minutes, 20:16 for hours and 31:24 for the day. The stopwatch count sits in bits 15:0. The enable and status words share one bit order: bit 0 second tick, bit 1 minute rollover, bit 2 day rollover, bit 3 daily alarm, bit 4 dated alarm, bit 5 stopwatch.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the time, alarms, stopwatch count, enables and status all read 0, and `irq` is low.
- R2: The seconds count advances once every `TICKS_PER_SEC` reference cycles. A write to address 0 restarts the prescaler, so the first advance comes exactly `TICKS_PER_SEC` cycles after the write edge.
- R3: Seconds and minutes wrap from 59 to 0 and hours from 23 to 0, each wrap carrying one into the next field. The day count wraps from 255 to 0.
- R4: Status bit 0 sets on every second tick, bit 1 when seconds wrap, and bit 2 when the hour wraps (day rollover), each only while its enable bit is set.
- R5: Status bit 3 sets when the time steps onto the hour, minute and second held at address 1, on any day, while enable bit 3 is set.
- R6: Status bit 4 sets only when the time steps onto the day, hour, minute and second held at address 2, while enable bit 4 is set.
- R7: While enable bit 5 is set, the stopwatch count drops by one at every minute rollover. A step taken at 0 wraps the count to all ones and sets status bit 5.
- R8: Writing address 5 clears each status bit written as 1. Bits written as 0 keep their value.
- R9: `irq` is high exactly when some status bit and its enable bit are both set. Clearing an enable drops `irq` without clearing status.
- R10: A source whose enable bit is clear never sets its status bit, and a disabled stopwatch holds its count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (nominally 32.768 kHz) |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Combinational read data |
| irq | output | 1 | Combined interrupt request |

## Verification
The range assertions assume software loads only legal time values: seconds and minutes below 60, hours below 24. The stimulus draws every loaded field within those limits and biases some draws toward 59, 59 and 23 so that the carries get exercised. The stepping assertions assume no write to the time register lands between a tick and its effect. The bench writes time only in whole cycles, from a negative clock edge, so this holds.

// File: rtl/rtc_pkg.sv
// Shared types, register addresses and event-bit positions for the RTC.
// Assumes a 32-bit register bus. Field positions in the word are fixed.
package rtc_pkg;
    localparam int ADDR_W  = 3;
    localparam int DATA_W  = 32;
    localparam int NUM_SRC = 6;

    localparam logic [ADDR_W-1:0] A_TIME  = 3'd0;
    localparam logic [ADDR_W-1:0] A_ALM_D = 3'd1;
    localparam logic [ADDR_W-1:0] A_ALM_F = 3'd2;
    localparam logic [ADDR_W-1:0] A_SW    = 3'd3;
    localparam logic [ADDR_W-1:0] A_EN    = 3'd4;
    localparam logic [ADDR_W-1:0] A_STAT  = 3'd5;

    localparam int EV_SEC  = 0;
    localparam int EV_MIN  = 1;
    localparam int EV_DAY  = 2;
    localparam int EV_ALMD = 3;
    localparam int EV_ALMF = 4;
    localparam int EV_SW   = 5;

    typedef struct packed {
        logic [7:0] day;
        logic [4:0] hour;
        logic [5:0] min;
        logic [5:0] sec;
    } rtc_time_t;

    // Pack a time value into the bus word layout.
    function automatic logic [DATA_W-1:0] time_to_word(rtc_time_t t);
        return {t.day, 3'b000, t.hour, 2'b00, t.min, 2'b00, t.sec};
    endfunction

    // Extract a time value from a bus word.
    function automatic rtc_time_t word_to_time(logic [DATA_W-1:0] w);
        rtc_time_t t;
        t.day  = w[31:24];
        t.hour = w[20:16];
        t.min  = w[13:8];
        t.sec  = w[5:0];
        return t;
    endfunction
endpackage

// File: rtl/rtc_prescaler.sv
// Divides the reference clock into a one-cycle tick per second.
// Assumes TICKS_PER_SEC >= 2. A restart forces the count back to zero
// and suppresses any tick in that cycle.
module rtc_prescaler #(
    parameter int TICKS_PER_SEC = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int CW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

    logic [CW-1:0] cnt_q;

    // Tick on the last count of each period unless being restarted.
    assign tick = (cnt_q == LAST) && !restart;

    // Cycle counter with restart and wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || tick) cnt_q <= '0;
        else                           cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/rtc_time_chain.sv
// Cascaded seconds/minutes/hours/day counters with carry outputs.
// Assumes loaded fields are in range. It wraps on >= the limit for safety.
module rtc_time_chain
    import rtc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      load,
    input  rtc_time_t load_val,
    output rtc_time_t now_t,
    output rtc_time_t next_t,
    output logic      min_step,
    output logic      hour_step,
    output logic      day_step
);
    logic sec_wrap, min_wrap, hour_wrap;

    // Compute the time one second ahead and the wrap conditions.
    always_comb begin
        sec_wrap  = now_t.sec  >= 6'd59;
        min_wrap  = now_t.min  >= 6'd59;
        hour_wrap = now_t.hour >= 5'd23;
        next_t    = now_t;
        next_t.sec = sec_wrap ? 6'd0 : now_t.sec + 6'd1;
        if (sec_wrap) begin
            next_t.min = min_wrap ? 6'd0 : now_t.min + 6'd1;
            if (min_wrap) begin
                next_t.hour = hour_wrap ? 5'd0 : now_t.hour + 5'd1;
                if (hour_wrap) next_t.day = now_t.day + 8'd1;
            end
        end
    end

    // Carry pulses, qualified by the tick.
    assign min_step  = tick && sec_wrap;
    assign hour_step = min_step && min_wrap;
    assign day_step  = hour_step && hour_wrap;

    // Time register: a load wins over a tick.
    always_ff @(posedge clk) begin
        if (!rst_n)    now_t <= '0;
        else if (load) now_t <= load_val;
        else if (tick) now_t <= next_t;
    end
endmodule

// File: rtl/rtc_alarm.sv
// Compares the time about to be entered against a target.
// MATCH_DAY selects whether the day field takes part in the match.
module rtc_alarm
    import rtc_pkg::*;
#(
    parameter bit MATCH_DAY = 1'b0
) (
    input  logic      tick,
    input  rtc_time_t cand,
    input  rtc_time_t target,
    output logic      hit
);
    logic tod_eq;

    assign tod_eq = (cand.hour == target.hour) && (cand.min == target.min)
                 && (cand.sec == target.sec);

    generate
        if (MATCH_DAY) begin : g_dated
            assign hit = tick && tod_eq && (cand.day == target.day);
        end else begin : g_daily
            assign hit = tick && tod_eq;
        end
    endgenerate
endmodule

// File: rtl/rtc_stopwatch.sv
// Minute-step countdown. It wraps below zero and flags the wrap.
// Assumes step is a one-cycle pulse per minute. A load wins over a step.
module rtc_stopwatch #(
    parameter int SW_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            step,
    input  logic            load,
    input  logic [SW_W-1:0] load_val,
    output logic [SW_W-1:0] count,
    output logic            underflow
);
    // Underflow when stepping from zero.
    assign underflow = run && step && !load && (count == '0);

    // Countdown register.
    always_ff @(posedge clk) begin
        if (!rst_n)            count <= '0;
        else if (load)         count <= load_val;
        else if (run && step)  count <= count - 1'b1;
    end
endmodule

// File: rtl/rtc_calendar.sv
// Top of the real-time clock: register port, event status and interrupt.
// Assumes single-cycle write strobes. Reads are combinational on rd_addr.
module rtc_calendar
    import rtc_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768,
    parameter int SW_W          = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);
    localparam int N_ALM = 2;

    logic              time_wr, sw_wr;
    logic              sec_tick, min_step, hour_step, day_step;
    rtc_time_t         now_t, next_t;
    rtc_time_t         alm_q [N_ALM];
    logic [N_ALM-1:0]  alm_hit;
    logic [NUM_SRC-1:0] enable_q, status_q, events;
    logic [SW_W-1:0]   sw_count;
    logic              sw_run, sw_under;
    logic              unused_bits;

    assign time_wr = wr_en && (wr_addr == A_TIME);
    assign sw_wr   = wr_en && (wr_addr == A_SW);
    assign sw_run  = enable_q[EV_SW];
    assign unused_bits = ^wr_data;

    rtc_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (time_wr),
        .tick    (sec_tick)
    );

    rtc_time_chain u_chain (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (sec_tick),
        .load      (time_wr),
        .load_val  (word_to_time(wr_data)),
        .now_t     (now_t),
        .next_t    (next_t),
        .min_step  (min_step),
        .hour_step (hour_step),
        .day_step  (day_step)
    );

    // One alarm per target register. Index 1 also matches the day.
    generate
        for (genvar g = 0; g < N_ALM; g++) begin : g_alm
            localparam logic [ADDR_W-1:0] MY_ADDR = A_ALM_D + ADDR_W'(g);

            // Alarm target register.
            always_ff @(posedge clk) begin
                if (!rst_n)                           alm_q[g] <= '0;
                else if (wr_en && wr_addr == MY_ADDR) alm_q[g] <= word_to_time(wr_data);
            end

            rtc_alarm #(.MATCH_DAY(g == 1)) u_alm (
                .tick   (sec_tick),
                .cand   (next_t),
                .target (alm_q[g]),
                .hit    (alm_hit[g])
            );
        end
    endgenerate

    rtc_stopwatch #(.SW_W(SW_W)) u_sw (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (sw_run),
        .step      (min_step),
        .load      (sw_wr),
        .load_val  (wr_data[SW_W-1:0]),
        .count     (sw_count),
        .underflow (sw_under)
    );

    // Gather the raw event pulses in status-bit order.
    always_comb begin
        events          = '0;
        events[EV_SEC]  = sec_tick;
        events[EV_MIN]  = min_step;
        events[EV_DAY]  = day_step;
        events[EV_ALMD] = alm_hit[0];
        events[EV_ALMF] = alm_hit[1];
        events[EV_SW]   = sw_under;
    end

    // Enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)                          enable_q <= '0;
        else if (wr_en && wr_addr == A_EN)   enable_q <= wr_data[NUM_SRC-1:0];
    end

    // Sticky status: write-1 clears, a new enabled event sets (set wins).
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~((wr_en && wr_addr == A_STAT) ?
                                              wr_data[NUM_SRC-1:0] : '0))
                              | (events & enable_q);
    end

    assign irq = |(status_q & enable_q);

    // Read multiplexer.
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_TIME:  rd_data = time_to_word(now_t);
            A_ALM_D: rd_data = time_to_word(alm_q[0]);
            A_ALM_F: rd_data = time_to_word(alm_q[1]);
            A_SW:    rd_data[SW_W-1:0] = sw_count;
            A_EN:    rd_data[NUM_SRC-1:0] = enable_q;
            A_STAT:  rd_data[NUM_SRC-1:0] = status_q;
            default: rd_data = '0;
        endcase
    end

    logic unused_steps;
    assign unused_steps = hour_step;
endmodule

// File: rtl/rtc_calendar_chk.sv
// Property checker for rtc_calendar, attached by bind.
// Assumes loaded time fields are in range.
module rtc_calendar_chk
    import rtc_pkg::*;
#(
    parameter int SW_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              tick,
    input rtc_time_t         cur,
    input logic [NUM_SRC-1:0] status,
    input logic [SW_W-1:0]   sw_cnt,
    input logic              sw_run,
    input logic              irq
);
    logic t_wr, s_wr, sw_wr;
    assign t_wr  = wr_en && (wr_addr == A_TIME);
    assign s_wr  = wr_en && (wr_addr == A_STAT);
    assign sw_wr = wr_en && (wr_addr == A_SW);

    // R3: fields stay in their ranges
    p_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cur.sec < 6'd60) && (cur.min < 6'd60) && (cur.hour < 5'd24));

    // R2: a tick moves the seconds
    p_sec_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(tick) && !$past(t_wr)) |-> (cur.sec != $past(cur.sec)));

    // R2: without tick or write the time holds
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(tick) && !$past(t_wr)) |-> $stable(cur));

    // R3: seconds wrap carries into minutes
    p_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(t_wr) && $past(cur.sec) == 6'd59 && cur.sec == 6'd0)
        |-> (cur.min != $past(cur.min)));

    // R8: a status bit only falls after a status write
    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(status) & ~status)) |-> $past(s_wr));

    // R9: no interrupt without status
    p_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status != '0));

    // R10: idle stopwatch holds its count
    p_sw_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(sw_run) && !$past(sw_wr)) |-> $stable(sw_cnt));
endmodule

bind rtc_calendar rtc_calendar_chk #(.SW_W(SW_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .tick    (sec_tick),
    .cur     (now_t),
    .status  (status_q),
    .sw_cnt  (sw_count),
    .sw_run  (sw_run),
    .irq     (irq)
);

// File: tb/rtc_calendar_bench.sv
// Self-checking bench: directed corners plus seeded random time runs.
module rtc_calendar_bench;
    localparam int T = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq;
    int          nvec = 0;
    int          nerr = 0;

    always #5 clk = ~clk;

    rtc_calendar #(.TICKS_PER_SEC(T), .SW_W(16)) u_rtc_calendar (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
    );

    function automatic logic [31:0] tw(int d, int h, int m, int s);
        return {8'(d), 3'b0, 5'(h), 2'b0, 6'(m), 2'b0, 6'(s)};
    endfunction

    // Expected time after n seconds.
    function automatic logic [31:0] adv(logic [31:0] w, int n);
        int d = int'(w[31:24]);
        int h = int'(w[20:16]);
        int m = int'(w[13:8]);
        int s = int'(w[5:0]);
        for (int i = 0; i < n; i++) begin
            s++;
            if (s == 60) begin
                s = 0; m++;
                if (m == 60) begin
                    m = 0; h++;
                    if (h == 24) begin h = 0; d = (d + 1) % 256; end
                end
            end
        end
        return tw(d, h, m, s);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a negedge; write lands on the next posedge.
    task automatic wr(logic [2:0] a, logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] d);
        rd_addr = a; #1; d = rd_data;
    endtask

    task automatic secs(int n);
        repeat (n * T) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        logic [31:0] v, t0;
        void'($urandom(32'd2718));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), v); chk("R1", v, 32'd0);
        end
        chk("R1 irq", {31'd0, irq}, 32'd0);

        // R2 exact tick position
        wr(3'd0, tw(3, 4, 5, 6));
        repeat (T - 1) @(posedge clk);
        @(negedge clk);
        rd(3'd0, v); chk("R2 before", v, tw(3, 4, 5, 6));
        @(posedge clk); @(negedge clk);
        rd(3'd0, v); chk("R2 at tick", v, tw(3, 4, 5, 7));

        // R2/R3 random runs, biased toward carries
        wr(3'd4, 32'd0);
        for (int i = 0; i < 24; i++) begin
            int d, h, m, s, n;
            d = int'($urandom_range(0, 255));
            h = int'($urandom_range(0, 23));
            m = int'($urandom_range(0, 59));
            s = int'($urandom_range(0, 59));
            if (i % 2 == 0) begin
                s = int'($urandom_range(50, 59)); m = 59;
                if (i % 4 == 0) h = 23;
                if (i % 8 == 0) d = 255;
            end
            n = int'($urandom_range(1, 120));
            t0 = tw(d, h, m, s);
            wr(3'd0, t0);
            secs(n);
            rd(3'd0, v); chk("R2 R3 random", v, adv(t0, n));
        end

        // R4 periodic flags and R3 day wrap
        wr(3'd0, 32'd0);
        wr(3'd4, 32'h07);
        wr(3'd5, 32'h3F);
        wr(3'd0, tw(255, 23, 59, 58));
        secs(1);
        rd(3'd5, v); chk("R4 second flag", v, 32'h01);
        secs(1);
        rd(3'd5, v); chk("R4 day rollover flags", v, 32'h07);
        rd(3'd0, v); chk("R3 day wrap", v, 32'd0);
        chk("R9 irq set", {31'd0, irq}, 32'd1);

        // R9 enable gates irq, R8 write-one-to-clear
        wr(3'd4, 32'd0);
        chk("R9 irq gated", {31'd0, irq}, 32'd0);
        rd(3'd5, v); chk("R9 status kept", v, 32'h07);
        wr(3'd5, 32'h02);
        rd(3'd5, v); chk("R8 clear one", v, 32'h05);
        wr(3'd5, 32'h00);
        rd(3'd5, v); chk("R8 zero write", v, 32'h05);
        wr(3'd5, 32'h3F);

        // R5/R6 alarms
        wr(3'd0, 32'd0);
        wr(3'd1, tw(0, 10, 20, 30));
        wr(3'd2, tw(5, 10, 20, 30));
        wr(3'd4, 32'h18);
        wr(3'd0, tw(4, 10, 20, 28));
        secs(1);
        rd(3'd5, v); chk("R5 no early hit", v, 32'h00);
        secs(1);
        rd(3'd5, v); chk("R5 R6 daily only", v, 32'h08);
        wr(3'd5, 32'h3F);
        wr(3'd0, tw(5, 10, 20, 29));
        secs(1);
        rd(3'd5, v); chk("R6 dated hit", v, 32'h18);
        wr(3'd4, 32'd0);
        wr(3'd5, 32'h3F);
        wr(3'd0, tw(5, 10, 20, 29));
        secs(1);
        rd(3'd5, v); chk("R10 alarms disabled", v, 32'h00);

        // R7 stopwatch
        wr(3'd0, 32'd0);
        wr(3'd4, 32'h20);
        wr(3'd3, 32'd2);
        wr(3'd0, tw(0, 0, 0, 59));
        secs(1);
        rd(3'd3, v); chk("R7 step", v, 32'd1);
        wr(3'd0, tw(0, 0, 0, 59));
        secs(1);
        rd(3'd3, v); chk("R7 to zero", v, 32'd0);
        rd(3'd5, v); chk("R7 no flag yet", v, 32'h00);
        wr(3'd0, tw(0, 0, 0, 59));
        secs(1);
        rd(3'd3, v); chk("R7 underflow wrap", v, 32'h0000FFFF);
        rd(3'd5, v); chk("R7 underflow flag", v, 32'h20);
        chk("R9 stopwatch irq", {31'd0, irq}, 32'd1);

        // R10 disabled stopwatch holds
        wr(3'd4, 32'd0);
        wr(3'd5, 32'h3F);
        wr(3'd3, 32'd3);
        wr(3'd0, tw(0, 0, 0, 59));
        secs(1);
        rd(3'd3, v); chk("R10 stopwatch held", v, 32'd3);
        rd(3'd5, v); chk("R10 no flag", v, 32'h00);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule